// File: doc/BRIEF.md
# Program Flow Trace Packet Decoder

This block sits on a byte-wide processor trace stream and decodes it as it arrives, one byte per clock. It locks onto the stream through an alignment pattern. It then sorts each header byte into a packet class. Instruction-sync packets are decoded in full: they carry the current program counter and an optional context word. Software loads that context word with its own values, so the word works as a cheap channel for instrumentation data. Branch, waypoint and exception packets are framed and skipped, so that the byte after them is correctly read as the next header.

A global controller owns header classification. It hands each multi-byte packet to a dedicated packet engine with a one-cycle start pulse. It then waits for that engine's stop pulse before it reads another header. The number of context bytes in an instruction-sync packet is fixed at build time by a 2-bit parameter. The input follows valid/ready rules, but ready is always high: the decoder never applies back-pressure, and a byte is taken on every clock where valid is high. The two results leave as registered values, each with a one-cycle valid strobe. These outputs have no ready, so a consumer must take each value in the cycle its strobe is high.

Top module: `trace_flow_decoder`

## Requirements
- R1: While reset is asserted, both strobes are low, both result words read zero, and in_ready_o is high.
- R2: After reset, every byte is discarded until an alignment pattern has been accepted. The pattern is at least five consecutive 0x00 bytes followed by 0x80. A complete instruction-sync packet sent before that pattern produces no strobe.
- R3: A byte is accepted on a rising edge where in_valid_i is high. A strobe caused by that byte is high for exactly one cycle, starting at the next rising edge after the accepting one.
- R4: Header 0x08 starts an instruction-sync packet. The header is followed by four program-counter bytes, least significant first, then one information byte. sync_addr_o is loaded with the assembled value, and addr_valid_o pulses, as a result of the fourth address byte.
- R5: After the information byte come the context bytes. CTX_SEL selects their number: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives 2 and 2'b11 gives 4. They are assembled least significant first and zero-extended to 32 bits. instr_word_o is loaded, and instr_valid_o pulses, as a result of the last context byte.
- R6: With CTX_SEL = 2'b00, instr_valid_o never rises. The packet ends at the information byte, and the next byte is read as a header.
- R7: An odd header byte (bit 0 set) is a branch packet. If its bit 7 is clear, the packet is that one byte. Otherwise follow-on bytes are taken while their bit 7 is set, up to four of them. The fourth ends the packet whatever its bit 7 is. Branch packets raise no strobe.
- R8: Header 0x72 is a waypoint packet. It is followed by one to five payload bytes, and a payload byte with bit 7 clear ends it. The fifth payload byte always ends it. No strobe is raised.
- R9: Header 0x76 is an exception packet of exactly one further byte. That byte is skipped whatever its value.
- R10: Once aligned, an even header byte other than 0x08, 0x72 or 0x76 is ignored. This includes 0x00 and 0x80.
- R11: in_ready_o stays high at all times. Cycles with in_valid_i low change no decode state, whatever in_data_i holds.
- R12: The byte directly after the last byte of a packet is read as a header, with no idle byte needed.
- R13: Bytes inside a packet are never taken as headers, even when they equal a header value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Trace byte valid |
| in_ready_o | output | 1 | Always high; the decoder never stalls |
| in_data_i | input | 8 | Trace byte |
| sync_addr_o | output | ADDR_W | Last decoded program counter |
| addr_valid_o | output | 1 | One-cycle strobe: sync_addr_o was just updated |
| instr_word_o | output | WORD_W | Last recovered instrumentation word |
| instr_valid_o | output | 1 | One-cycle strobe: instr_word_o was just updated |

## Verification
A wrong packet length, such as a branch engine that stops one byte late, makes the decoder lose framing. The fault shows at the ports on the next instruction-sync packet. That packet is then missed or mis-assembled, and addr_valid_o arrives at the wrong time or with a shifted value. Errors in the alignment hunt show as strobes from packets sent before the pattern, or as strobes missing after it. The bench compares both strobes in every cycle, so a framing slip is reported within one packet of where it happened. Four instances with different context sizes cover each length branch.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [1:0] {
    G_HUNT,
    G_IDLE,
    G_BUSY,
    G_EXC
  } glob_st_t;

  typedef enum logic [1:0] {
    IS_WAIT,
    IS_ADDR,
    IS_INFO,
    IS_CTX
  } isync_st_t;

  localparam logic [7:0] HDR_ISYNC = 8'h08;
  localparam logic [7:0] HDR_WAYPT = 8'h72;
  localparam logic [7:0] HDR_EXCPT = 8'h76;
  localparam logic [7:0] ALIGN_END = 8'h80;

  function automatic int unsigned ctx_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b10:   return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/trace_isync_fsm.sv
module trace_isync_fsm
  import trace_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WORD_W  = 32,
  parameter logic [1:0]  CTX_SEL = 2'b11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              vld_i,
  input  logic [7:0]        byte_i,
  output logic              stop_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);

  localparam int unsigned ADDR_BYTES = ADDR_W / 8;
  localparam int unsigned CTX_BYTES  = ctx_bytes(CTX_SEL);
  localparam int unsigned CTX_LAST   = (CTX_BYTES == 0) ? 0 : CTX_BYTES - 1;
  localparam int unsigned CNT_MAX    = (ADDR_BYTES > 4) ? ADDR_BYTES : 4;
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);

  isync_st_t          st;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr_acc, addr_next;
  logic [WORD_W-1:0]  word_acc, word_next;
  logic               addr_last, ctx_last;

  always_comb begin
    addr_next = addr_acc | (ADDR_W'(byte_i) << {cnt, 3'b000});
    word_next = word_acc | (WORD_W'(byte_i) << {cnt, 3'b000});
    addr_last = (cnt == CNT_W'(ADDR_BYTES - 1));
    ctx_last  = (cnt == CNT_W'(CTX_LAST));
    stop_o    = vld_i && (((st == IS_INFO) && (CTX_BYTES == 0)) ||
                          ((st == IS_CTX) && ctx_last));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st           <= IS_WAIT;
      cnt          <= '0;
      addr_acc     <= '0;
      word_acc     <= '0;
      addr_o       <= '0;
      word_o       <= '0;
      addr_valid_o <= 1'b0;
      word_valid_o <= 1'b0;
    end else begin
      addr_valid_o <= 1'b0;
      word_valid_o <= 1'b0;
      case (st)
        IS_WAIT: begin
          if (start_i) begin
            st       <= IS_ADDR;
            cnt      <= '0;
            addr_acc <= '0;
            word_acc <= '0;
          end
        end
        IS_ADDR: begin
          if (vld_i) begin
            addr_acc <= addr_next;
            if (addr_last) begin
              addr_o       <= addr_next;
              addr_valid_o <= 1'b1;
              cnt          <= '0;
              st           <= IS_INFO;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        IS_INFO: begin
          if (vld_i) begin
            cnt <= '0;
            st  <= (CTX_BYTES == 0) ? IS_WAIT : IS_CTX;
          end
        end
        default: begin
          if (vld_i) begin
            word_acc <= word_next;
            if (ctx_last) begin
              word_o       <= word_next;
              word_valid_o <= 1'b1;
              st           <= IS_WAIT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R13
  isync_start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (st == IS_WAIT));

  // R5
  word_from_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> ($past(st) == IS_CTX));

  // R3
  addr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> !addr_valid_o);

endmodule

// File: rtl/trace_follow_fsm.sv
module trace_follow_fsm #(
  parameter int unsigned MAX_FOLLOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic vld_i,
  input  logic cont_i,
  output logic stop_o
);

  localparam int unsigned CNT_W = $clog2(MAX_FOLLOW + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    stop_o = busy && vld_i && (!cont_i || (cnt == CNT_W'(MAX_FOLLOW - 1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start_i) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && vld_i) begin
      if (stop_o) busy <= 1'b0;
      else        cnt  <= cnt + 1'b1;
    end
  end

  // R13
  follow_start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy);

  // R7
  follow_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (cnt < CNT_W'(MAX_FOLLOW)));

endmodule

// File: rtl/trace_flow_decoder.sv
module trace_flow_decoder
  import trace_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned WORD_W        = 32,
  parameter logic [1:0]  CTX_SEL       = 2'b11,
  parameter int unsigned ALIGN_ZEROS   = 5,
  parameter int unsigned BRANCH_FOLLOW = 4,
  parameter int unsigned WAYPT_FOLLOW  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  output logic [ADDR_W-1:0] sync_addr_o,
  output logic              addr_valid_o,
  output logic [WORD_W-1:0] instr_word_o,
  output logic              instr_valid_o
);

  localparam int unsigned ZC_W = $clog2(ALIGN_ZEROS + 1);

  logic [7:0]      byte_q;
  logic            vld_q;
  logic [ZC_W-1:0] zc;
  glob_st_t        gs, gs_next;
  logic            start_is, start_br, start_wp;
  logic            stop_is, stop_br, stop_wp, stop_any;
  logic            classify, align_hit, zero_track;

  assign in_ready_o = 1'b1;

  // input stage: all decisions use the registered byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      byte_q <= in_data_i;
      vld_q  <= in_valid_i;
    end
  end

  always_comb begin
    classify   = vld_q && (gs == G_IDLE);
    align_hit  = (byte_q == ALIGN_END) && (zc == ZC_W'(ALIGN_ZEROS));
    zero_track = (gs == G_HUNT) || (gs == G_IDLE);
    start_is   = classify && (byte_q == HDR_ISYNC);
    start_wp   = classify && (byte_q == HDR_WAYPT);
    start_br   = classify && byte_q[0] && byte_q[7];
    stop_any   = stop_is || stop_br || stop_wp;
    gs_next    = gs;
    case (gs)
      G_HUNT: if (vld_q && align_hit) gs_next = G_IDLE;
      G_IDLE: begin
        if (start_is || start_wp || start_br) gs_next = G_BUSY;
        else if (classify && (byte_q == HDR_EXCPT)) gs_next = G_EXC;
      end
      G_BUSY: if (stop_any) gs_next = G_IDLE;
      default: if (vld_q) gs_next = G_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gs <= G_HUNT;
      zc <= '0;
    end else begin
      gs <= gs_next;
      if (vld_q) begin
        if (zero_track && (byte_q == 8'h00)) begin
          if (zc != ZC_W'(ALIGN_ZEROS)) zc <= zc + 1'b1;
        end else begin
          zc <= '0;
        end
      end
    end
  end

  trace_isync_fsm #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .CTX_SEL(CTX_SEL)
  ) u_isync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_is),
    .vld_i        (vld_q),
    .byte_i       (byte_q),
    .stop_o       (stop_is),
    .addr_o       (sync_addr_o),
    .addr_valid_o (addr_valid_o),
    .word_o       (instr_word_o),
    .word_valid_o (instr_valid_o)
  );

  trace_follow_fsm #(.MAX_FOLLOW(BRANCH_FOLLOW)) u_branch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_br),
    .vld_i  (vld_q),
    .cont_i (byte_q[7]),
    .stop_o (stop_br)
  );

  trace_follow_fsm #(.MAX_FOLLOW(WAYPT_FOLLOW)) u_waypt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_wp),
    .vld_i  (vld_q),
    .cont_i (byte_q[7]),
    .stop_o (stop_wp)
  );

  // R13
  start_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_is, start_br, start_wp}));

  // R13
  stop_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stop_is, stop_br, stop_wp}));

  // R2
  hunt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gs == G_HUNT) |-> (!addr_valid_o && !instr_valid_o));

  // R12
  instr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |-> (gs == G_IDLE));

endmodule

// File: tb/tb_trace_flow_decoder.sv
`timescale 1ns/1ps
module tb_trace_flow_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  v = 4'b0;
  logic [7:0]  din = 8'h00;
  logic [31:0] o_addr [4];
  logic [31:0] o_word [4];
  logic        o_av [4];
  logic        o_wv [4];
  logic        o_rdy [4];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit gaps_on = 1'b0;

  // index 0: four context bytes, 1: none, 2: one, 3: two
  int cb [4] = '{4, 0, 1, 2};

  logic [7:0]  bb   [0:4095];
  bit          bv   [0:4095];
  bit          ea_v [0:4095];
  bit          ew_v [0:4095];
  logic [31:0] ea   [0:4095];
  logic [31:0] ew   [0:4095];
  string       tg   [0:4095];
  int          nb;

  always #2.5 clk = ~clk;

  trace_flow_decoder #(.CTX_SEL(2'b11)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v[0]), .in_ready_o(o_rdy[0]),
    .in_data_i(din), .sync_addr_o(o_addr[0]), .addr_valid_o(o_av[0]),
    .instr_word_o(o_word[0]), .instr_valid_o(o_wv[0]));
  trace_flow_decoder #(.CTX_SEL(2'b00)) dut_c0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v[1]), .in_ready_o(o_rdy[1]),
    .in_data_i(din), .sync_addr_o(o_addr[1]), .addr_valid_o(o_av[1]),
    .instr_word_o(o_word[1]), .instr_valid_o(o_wv[1]));
  trace_flow_decoder #(.CTX_SEL(2'b01)) dut_c1 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v[2]), .in_ready_o(o_rdy[2]),
    .in_data_i(din), .sync_addr_o(o_addr[2]), .addr_valid_o(o_av[2]),
    .instr_word_o(o_word[2]), .instr_valid_o(o_wv[2]));
  trace_flow_decoder #(.CTX_SEL(2'b10)) dut_c2 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(v[3]), .in_ready_o(o_rdy[3]),
    .in_data_i(din), .sync_addr_o(o_addr[3]), .addr_valid_o(o_av[3]),
    .instr_word_o(o_word[3]), .instr_valid_o(o_wv[3]));

  function automatic logic [31:0] mask_word(input logic [31:0] w, input int n);
    if (n >= 4) return w;
    if (n == 2) return {16'h0, w[15:0]};
    if (n == 1) return {24'h0, w[7:0]};
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic push_raw(input logic [7:0] b, input bit valid, input string tag);
    bb[nb] = b; bv[nb] = valid; ea_v[nb] = 1'b0; ew_v[nb] = 1'b0;
    ea[nb] = '0; ew[nb] = '0; tg[nb] = tag;
    nb++;
  endtask

  // pushes one valid byte, optionally preceded by an idle cycle with junk data (R11)
  task automatic push(input logic [7:0] b, input string tag);
    if (gaps_on && ($urandom % 4 == 0)) push_raw(8'($urandom), 1'b0, "R11");
    push_raw(b, 1'b1, tag);
  endtask

  task automatic push_isync(input logic [31:0] a, input logic [31:0] w, input int n,
                            input bit expect_on, input string atag, input string wtag);
    push(8'h08, atag);
    for (int i = 0; i < 4; i++) push(a[8*i +: 8], atag);
    if (expect_on) begin ea_v[nb-1] = 1'b1; ea[nb-1] = a; end
    push(8'h21, (n == 0) ? "R6" : wtag);
    for (int i = 0; i < n; i++) push(w[8*i +: 8], wtag);
    if (expect_on && n > 0) begin ew_v[nb-1] = 1'b1; ew[nb-1] = mask_word(w, n); end
  endtask

  task automatic rand_packet(input int n);
    int kind;
    kind = int'($urandom % 6);
    case (kind)
      0, 1: push_isync($urandom, $urandom, n, 1'b1, "R4", "R5");
      2: begin
        int f;
        f = int'($urandom % 5);
        push({f > 0, 6'($urandom), 1'b1}, "R7");
        for (int j = 0; j < f; j++)
          push({(j < f - 1) ? 1'b1 : ((j == 3) ? 1'($urandom) : 1'b0), 7'($urandom)}, "R7");
      end
      3: begin
        int p;
        p = 1 + int'($urandom % 5);
        push(8'h72, "R8");
        for (int j = 0; j < p; j++)
          push({(j < p - 1) ? 1'b1 : ((j == 4) ? 1'($urandom) : 1'b0), 7'($urandom)}, "R8");
      end
      4: begin
        push(8'h76, "R9");
        push(8'($urandom), "R9");
      end
      default: begin
        logic [7:0] idle [6] = '{8'h00, 8'h80, 8'h02, 8'h04, 8'h10, 8'h44};
        push(idle[$urandom % 6], "R10");
      end
    endcase
  endtask

  task automatic check_item(input int k, input int idx);
    chk(o_av[k] === ea_v[idx], tg[idx], $sformatf("addr_valid inst%0d byte%0d", k, idx),
        32'(o_av[k]), 32'(ea_v[idx]));
    if (ea_v[idx])
      chk(o_addr[k] === ea[idx], tg[idx], $sformatf("sync_addr inst%0d byte%0d", k, idx),
          o_addr[k], ea[idx]);
    chk(o_wv[k] === ew_v[idx], tg[idx], $sformatf("instr_valid inst%0d byte%0d", k, idx),
        32'(o_wv[k]), 32'(ew_v[idx]));
    if (ew_v[idx])
      chk(o_word[k] === ew[idx], tg[idx], $sformatf("instr_word inst%0d byte%0d", k, idx),
          o_word[k], ew[idx]);
    chk(o_rdy[k] === 1'b1, "R11", "in_ready", 32'(o_rdy[k]), 32'd1);
  endtask

  // item i is driven at negedge i; its strobe is visible at negedge i+2 (R3)
  task automatic play(input int k);
    for (int i = 0; i < nb + 3; i++) begin
      @(negedge clk);
      if (i >= 2) check_item(k, i - 2);
      if (i < nb) begin
        din = bb[i];
        v   = bv[i] ? (4'b1 << k) : 4'b0;
      end else begin
        v = 4'b0;
      end
    end
  endtask

  task automatic build(input int k);
    int n;
    n  = cb[k];
    nb = 0;
    gaps_on = 1'b0;
    // R2: a full packet before alignment must be dropped
    push_isync(32'h001014c8, 32'h1234abcd, n, 1'b0, "R2", "R2");
    push(8'h81, "R2"); push(8'h00, "R2"); push(8'h80, "R2");
    for (int i = 0; i < 5; i++) push(8'h00, "R2");
    push(8'h80, "R2");
    // R4 R5 captured sequence
    push_isync(32'h001014c8, 32'h1234abcd, n, 1'b1, "R4", "R5");
    // R3 strobe timing on a second packet
    push_isync(32'hdeadbeef, 32'hcafe0102, n, 1'b1, "R3", "R3");
    // R7 single-byte branch, then longest branch with forced end
    push(8'h01, "R7");
    push(8'h81, "R7"); push(8'h80, "R7"); push(8'h80, "R7"); push(8'h80, "R7"); push(8'h80, "R7");
    push_isync(32'h00a0b0c0, 32'h11223344, n, 1'b1, "R7", "R7");
    // R8 longest waypoint, forced end on the fifth payload byte
    push(8'h72, "R8");
    push(8'h85, "R8"); push(8'h86, "R8"); push(8'h87, "R8"); push(8'h88, "R8"); push(8'h89, "R8");
    push_isync(32'h55667788, 32'h99aabbcc, n, 1'b1, "R8", "R8");
    push(8'h72, "R8"); push(8'h05, "R8");
    push_isync(32'h01020304, 32'h05060708, n, 1'b1, "R8", "R8");
    // R9 exception payload equal to a header value
    push(8'h76, "R9"); push(8'h08, "R9");
    push_isync(32'h0000ffff, 32'hffff0000, n, 1'b1, "R9", "R9");
    // R10 ignored even bytes
    push(8'h00, "R10"); push(8'h80, "R10"); push(8'h02, "R10"); push(8'h44, "R10");
    push_isync(32'h13579bdf, 32'h2468ace0, n, 1'b1, "R10", "R10");
    // R13 payload bytes that look like headers
    push_isync(32'h76728108, 32'h08727681, n, 1'b1, "R13", "R13");
    // R12 back-to-back packets
    push_isync(32'h0badf00d, 32'h0000beef, n, 1'b1, "R12", "R12");
    push_isync(32'h0000000f, 32'h0000000e, n, 1'b1, "R12", "R12");
    // R11 random traffic with idle cycles
    gaps_on = 1'b1;
    for (int p = 0; p < 40; p++) rand_packet(n);
    push_isync(32'hfeedface, 32'h87654321, n, 1'b1, "R11", "R11");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(o_av[k] === 1'b0, "R1", "reset addr_valid", 32'(o_av[k]), 32'd0);
      chk(o_wv[k] === 1'b0, "R1", "reset instr_valid", 32'(o_wv[k]), 32'd0);
      chk(o_addr[k] === 32'h0, "R1", "reset sync_addr", o_addr[k], 32'h0);
      chk(o_word[k] === 32'h0, "R1", "reset instr_word", o_word[k], 32'h0);
      chk(o_rdy[k] === 1'b1, "R1", "reset in_ready", 32'(o_rdy[k]), 32'd1);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      build(k);
      play(k);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog: got no completion expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule